// File: doc/BRIEF.md
# Paged Descriptor Ring Index Manager

This block keeps the index state for three circular descriptor rings: a request ring, a completion ring and a message ring. Each ring's entries are spread over a table of memory pages that need not be contiguous. For every ring the block holds a page-number table, a length mask and a free-running local counter. On a pop it forms the physical address of the next descriptor from the masked counter. It does not read or write the descriptors.

The shared ring-state area is modelled as a small register file inside the block. The other side writes the request producer index and the message consumer index there, and any field can be read back. The block writes its consumer and producer indices and each ring's log2 size into that file on flush and on initialisation. Operations arrive as a single-cycle code, one per cycle. A pop returns its address one cycle later, qualified by `addr_valid`. Two combinational flags report whether the request ring is empty and whether the message ring has room.

Top module: `pdr_index_mgr`

## Requirements
- R1: After reset `addr_valid` is 0, every shared field reads 0, `req_empty` is 1 and `msg_room` is 1.
- R2: Op 2 (init data rings) takes the request page count from `op_data[7:0]` and the completion page count from `op_data[15:8]`. It sets each ring's mask to all ones over the bit width of (pages × entries per page − 1), with a minimum width of 1. It stores that width in fields 2 (request) and 5 (completion), zeroes fields 0, 1, 3 and 4, and zeroes both local counters.
- R3: Op 1 writes page number `op_data` into entry `op_idx` of the table for ring `op_ring` (0 request, 1 completion, 2 message). A pop returns (page number << 12) + in-page index × descriptor size one cycle later. The page is the masked counter divided by the entries per page, and the in-page index is the remainder. Request pops use op 4, message pops use op 6, and the defaults are 32 entries of 128 bytes per page.
- R4: `req_empty` is 1 while field 0 equals the local request counter. A request pop in that state returns address 0 with `addr_valid` 1 and leaves the counter unchanged.
- R5: A completion pop (op 5, with defaults of 128 entries of 32 bytes per page) always advances, with no overflow check.
- R6: The page and the in-page index come from the masked counter, so the address wraps back to page 0, index 0 after (mask + 1) pops.
- R7: Op 7 writes the request counter to field 1 (request consumer). Op 8 writes the completion counter to field 3 and op 9 writes the message counter to field 6 (the producer fields).
- R8: `msg_room` is 1 exactly when (field 6 − field 7), taken modulo 2^32, is less than the message mask + 1.
- R9: Op 3 (init message ring, page count in `op_data[7:0]`) sets the message mask and counter, writes field 8 and zeroes fields 6 and 7, and touches no request or completion field.
- R10: Op 10 (clear) zeroes all masks, all local counters and all page tables but leaves the shared fields unchanged, so a later pop returns address 0.
- R11: A host write (`host_we`, field `host_sel`) takes effect at the clock edge. If an operation writes the same field in the same cycle, the operation's value is kept.
- R12: Local counters increment unmasked, so a flush reports the full count even after the ring has wrapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_code | input | 4 | Operation: 0 none, 1 page write, 2 init data, 3 init message, 4/5/6 pop request/completion/message, 7/8/9 flush request/completion/message, 10 clear |
| op_ring | input | 2 | Ring for a page write |
| op_idx | input | 5 | Page-table entry for a page write |
| op_data | input | 20 | Page number, or page counts for init |
| host_we | input | 1 | Shared-field write strobe |
| host_sel | input | 4 | Shared field written (0..8) |
| host_wdata | input | 32 | Shared-field write value |
| host_rsel | input | 4 | Shared field read |
| host_rdata | output | 32 | Read value, combinational |
| addr_valid | output | 1 | Pop result valid, one cycle after the pop |
| desc_addr | output | 32 | Descriptor address |
| req_empty | output | 1 | No request is pending |
| msg_room | output | 1 | Message ring has room |

## Verification
A wrong mask or page table appears at `desc_addr` on the first pop that crosses a page or wraps the ring, which is one cycle after that pop. A counter that advances on an empty request pop, or that is stored masked, shows up at the next flush as a wrong consumer field. It also shows in `req_empty` as soon as the host moves the producer index. Faults in field priority and in the message-room window show on `host_rdata` and `msg_room` in the cycle right after the write. The bench therefore walks pops across page and wrap boundaries and reads the shared fields back after every flush and init.

// File: rtl/pdr_pkg.sv
package pdr_pkg;

   typedef enum logic [3:0] {
      OP_NOP        = 4'd0,
      OP_PAGE_WR    = 4'd1,
      OP_INIT_DATA  = 4'd2,
      OP_INIT_MSG   = 4'd3,
      OP_POP_REQ    = 4'd4,
      OP_POP_CMP    = 4'd5,
      OP_POP_MSG    = 4'd6,
      OP_FLUSH_REQ  = 4'd7,
      OP_FLUSH_CMP  = 4'd8,
      OP_FLUSH_MSG  = 4'd9,
      OP_CLEAR      = 4'd10
   } op_e;

   // shared ring-state field numbers
   localparam int SF_REQ_PROD = 0;
   localparam int SF_REQ_CONS = 1;
   localparam int SF_REQ_LOG2 = 2;
   localparam int SF_CMP_PROD = 3;
   localparam int SF_CMP_CONS = 4;
   localparam int SF_CMP_LOG2 = 5;
   localparam int SF_MSG_PROD = 6;
   localparam int SF_MSG_CONS = 7;
   localparam int SF_MSG_LOG2 = 8;
   localparam int NUM_SF      = 9;

   localparam int NUM_RINGS   = 3;

   // bits needed to hold v; zero still takes one bit
   function automatic int unsigned bit_width(input logic [63:0] v);
      int unsigned w;
      w = 1;
      for (int i = 0; i < 64; i++) begin
         if (v[i]) w = i + 1;
      end
      return w;
   endfunction

endpackage

// File: rtl/pdr_ring_lane.sv
module pdr_ring_lane #(
   parameter int MAX_PAGES  = 32,
   parameter int EPP        = 32,
   parameter int DESC_BYTES = 128,
   parameter int PPN_W      = 20,
   parameter int PAGE_SHIFT = 12,
   parameter int CNT_W      = 32,
   parameter int PCNT_W     = 8,
   parameter int IDX_W      = 5,
   parameter int LOG_W      = 6,
   parameter int ADDR_W     = PPN_W + PAGE_SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              pg_we,
   input  logic [IDX_W-1:0]  pg_idx,
   input  logic [PPN_W-1:0]  pg_ppn,
   input  logic              init,
   input  logic [PCNT_W-1:0] init_pages,
   input  logic              adv,
   output logic [CNT_W-1:0]  cnt,
   output logic [CNT_W-1:0]  mask,
   output logic [LOG_W-1:0]  init_log,
   output logic [ADDR_W-1:0] desc_addr
);
   import pdr_pkg::*;

   localparam int EPP_LOG  = $clog2(EPP);
   localparam int DESC_LOG = $clog2(DESC_BYTES);
   localparam bit DESC_P2  = ((DESC_BYTES & (DESC_BYTES - 1)) == 0);

   if (EPP < 2 || (EPP & (EPP - 1)) != 0) begin : g_bad_epp
      $error("entries per page must be a power of two, at least 2");
   end
   if (EPP * DESC_BYTES > (1 << PAGE_SHIFT)) begin : g_bad_fit
      $error("descriptors of one page exceed the page size");
   end
   if (MAX_PAGES < 1 || MAX_PAGES > (1 << IDX_W)) begin : g_bad_pages
      $error("page table depth does not match its index width");
   end

   logic [PPN_W-1:0]  ppn_q [MAX_PAGES];
   logic [CNT_W-1:0]  cnt_q, mask_q, new_mask;
   logic [63:0]       entries;
   int unsigned       span;

   always_comb begin
      entries = 64'(init_pages) * 64'(EPP);
      span    = bit_width(entries - 64'd1);
      if (span > CNT_W) span = CNT_W;
      new_mask = (span >= CNT_W) ? '1 : ((CNT_W'(1) << span) - CNT_W'(1));
      init_log = LOG_W'(span);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt_q  <= '0;
         mask_q <= '0;
         for (int i = 0; i < MAX_PAGES; i++) ppn_q[i] <= '0;
      end else begin
         if (init) begin
            cnt_q  <= '0;
            mask_q <= new_mask;
         end else if (adv) begin
            cnt_q  <= cnt_q + CNT_W'(1);
         end
         if (pg_we && (32'(pg_idx) < MAX_PAGES)) ppn_q[pg_idx] <= pg_ppn;
      end
   end

   // address of the descriptor the counter points at
   logic [CNT_W-1:0]   masked, page_no;
   logic [EPP_LOG-1:0] in_idx;
   logic [ADDR_W-1:0]  base, offs;

   always_comb begin
      masked  = cnt_q & mask_q;
      page_no = masked >> EPP_LOG;
      in_idx  = masked[EPP_LOG-1:0];
      if (page_no < CNT_W'(MAX_PAGES))
         base = {ppn_q[page_no[IDX_W-1:0]], {PAGE_SHIFT{1'b0}}};
      else
         base = '0;
   end

   if (DESC_P2) begin : g_off_shift
      assign offs = ADDR_W'(in_idx) << DESC_LOG;
   end else begin : g_off_mul
      assign offs = ADDR_W'(in_idx) * ADDR_W'(DESC_BYTES);
   end

   assign desc_addr = base + offs;
   assign cnt       = cnt_q;
   assign mask      = mask_q;

   // R12
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !clr && !init) |=> cnt == $past(cnt) + CNT_W'(1));
   // R10
   clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0 && mask == '0));
   // R2
   init_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (init && !clr) |=> (cnt == '0 && mask[0]));

endmodule

// File: rtl/pdr_shared_regs.sv
module pdr_shared_regs #(
   parameter int CNT_W = 32,
   parameter int LOG_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_we,
   input  logic [3:0]       host_sel,
   input  logic [CNT_W-1:0] host_wdata,
   input  logic [3:0]       host_rsel,
   output logic [CNT_W-1:0] host_rdata,
   input  logic             init_data,
   input  logic [LOG_W-1:0] req_log,
   input  logic [LOG_W-1:0] cmp_log,
   input  logic             init_msg,
   input  logic [LOG_W-1:0] msg_log,
   input  logic             flush_req,
   input  logic [CNT_W-1:0] req_cnt,
   input  logic             flush_cmp,
   input  logic [CNT_W-1:0] cmp_cnt,
   input  logic             flush_msg,
   input  logic [CNT_W-1:0] msg_cnt,
   output logic [CNT_W-1:0] req_prod,
   output logic [CNT_W-1:0] msg_prod,
   output logic [CNT_W-1:0] msg_cons
);
   import pdr_pkg::*;

   if (LOG_W < 1 || LOG_W > CNT_W) begin : g_bad_log
      $error("log field width out of range");
   end

   logic [CNT_W-1:0] sf_q [NUM_SF];

   // later assignments win: block operations override the host
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_SF; i++) sf_q[i] <= '0;
      end else begin
         if (host_we && (32'(host_sel) < NUM_SF)) sf_q[host_sel] <= host_wdata;
         if (init_data) begin
            sf_q[SF_REQ_PROD] <= '0;
            sf_q[SF_REQ_CONS] <= '0;
            sf_q[SF_REQ_LOG2] <= CNT_W'(req_log);
            sf_q[SF_CMP_PROD] <= '0;
            sf_q[SF_CMP_CONS] <= '0;
            sf_q[SF_CMP_LOG2] <= CNT_W'(cmp_log);
         end
         if (init_msg) begin
            sf_q[SF_MSG_PROD] <= '0;
            sf_q[SF_MSG_CONS] <= '0;
            sf_q[SF_MSG_LOG2] <= CNT_W'(msg_log);
         end
         if (flush_req) sf_q[SF_REQ_CONS] <= req_cnt;
         if (flush_cmp) sf_q[SF_CMP_PROD] <= cmp_cnt;
         if (flush_msg) sf_q[SF_MSG_PROD] <= msg_cnt;
      end
   end

   assign host_rdata = (32'(host_rsel) < NUM_SF) ? sf_q[host_rsel] : '0;
   assign req_prod   = sf_q[SF_REQ_PROD];
   assign msg_prod   = sf_q[SF_MSG_PROD];
   assign msg_cons   = sf_q[SF_MSG_CONS];

   // R7
   flush_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_req |=> sf_q[SF_REQ_CONS] == $past(req_cnt));
   // R2
   init_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_data |=> (req_prod == '0 && sf_q[SF_CMP_PROD] == '0));

endmodule

// File: rtl/pdr_index_mgr.sv
module pdr_index_mgr #(
   parameter int PAGE_SHIFT = 12,
   parameter int PPN_W      = 20,
   parameter int CNT_W      = 32,
   parameter int DATA_PAGES = 32,
   parameter int MSG_PAGES  = 16,
   parameter int REQ_EPP    = 32,
   parameter int REQ_DESC   = 128,
   parameter int CMP_EPP    = 128,
   parameter int CMP_DESC   = 32,
   parameter int MSG_EPP    = 32,
   parameter int MSG_DESC   = 128,
   parameter int PCNT_W     = 8,
   localparam int ADDR_W    = PPN_W + PAGE_SHIFT,
   localparam int MAXP      = (DATA_PAGES > MSG_PAGES) ? DATA_PAGES : MSG_PAGES,
   localparam int OPIDX_W   = (MAXP > 1) ? $clog2(MAXP) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [3:0]         op_code,
   input  logic [1:0]         op_ring,
   input  logic [OPIDX_W-1:0] op_idx,
   input  logic [PPN_W-1:0]   op_data,
   input  logic               host_we,
   input  logic [3:0]         host_sel,
   input  logic [CNT_W-1:0]   host_wdata,
   input  logic [3:0]         host_rsel,
   output logic [CNT_W-1:0]   host_rdata,
   output logic               addr_valid,
   output logic [ADDR_W-1:0]  desc_addr,
   output logic               req_empty,
   output logic               msg_room
);
   import pdr_pkg::*;

   localparam int LOG_W = $clog2(CNT_W + 1);
   localparam int LANE_PAGES [NUM_RINGS] = '{DATA_PAGES, DATA_PAGES, MSG_PAGES};
   localparam int LANE_EPP   [NUM_RINGS] = '{REQ_EPP, CMP_EPP, MSG_EPP};
   localparam int LANE_DESC  [NUM_RINGS] = '{REQ_DESC, CMP_DESC, MSG_DESC};

   if (2 * PCNT_W > PPN_W) begin : g_bad_pcnt
      $error("two page counts must fit in the operand");
   end
   if ((1 << PCNT_W) - 1 > MAXP * 256) begin : g_bad_pcnt_w
      $error("page count field wider than needed");
   end

   op_e op;
   assign op = op_e'(op_code);

   logic [CNT_W-1:0]  lane_cnt  [NUM_RINGS];
   logic [CNT_W-1:0]  lane_mask [NUM_RINGS];
   logic [LOG_W-1:0]  lane_log  [NUM_RINGS];
   logic [ADDR_W-1:0] lane_addr [NUM_RINGS];
   logic              lane_pgwe [NUM_RINGS];
   logic              lane_init [NUM_RINGS];
   logic              lane_adv  [NUM_RINGS];
   logic              clr;
   logic [CNT_W-1:0]  sh_req_prod, sh_msg_prod, sh_msg_cons;

   assign clr       = (op == OP_CLEAR);
   assign req_empty = (sh_req_prod == lane_cnt[0]);

   always_comb begin
      for (int r = 0; r < NUM_RINGS; r++) begin
         lane_pgwe[r] = (op == OP_PAGE_WR) && (32'(op_ring) == r);
         lane_init[r] = (r < 2) ? (op == OP_INIT_DATA) : (op == OP_INIT_MSG);
      end
      lane_adv[0] = (op == OP_POP_REQ) && !req_empty;
      lane_adv[1] = (op == OP_POP_CMP);
      lane_adv[2] = (op == OP_POP_MSG);
   end

   for (genvar g = 0; g < NUM_RINGS; g++) begin : g_lane
      localparam int PG = LANE_PAGES[g];
      localparam int IW = (PG > 1) ? $clog2(PG) : 1;
      logic [PCNT_W-1:0] pages;
      if (g == 1) begin : g_hi
         assign pages = op_data[2*PCNT_W-1:PCNT_W];
      end else begin : g_lo
         assign pages = op_data[PCNT_W-1:0];
      end
      pdr_ring_lane #(
         .MAX_PAGES (PG),
         .EPP       (LANE_EPP[g]),
         .DESC_BYTES(LANE_DESC[g]),
         .PPN_W     (PPN_W),
         .PAGE_SHIFT(PAGE_SHIFT),
         .CNT_W     (CNT_W),
         .PCNT_W    (PCNT_W),
         .IDX_W     (IW),
         .LOG_W     (LOG_W),
         .ADDR_W    (ADDR_W)
      ) u_lane (
         .clk       (clk),
         .rst_n     (rst_n),
         .clr       (clr),
         .pg_we     (lane_pgwe[g]),
         .pg_idx    (op_idx[IW-1:0]),
         .pg_ppn    (op_data),
         .init      (lane_init[g]),
         .init_pages(pages),
         .adv       (lane_adv[g]),
         .cnt       (lane_cnt[g]),
         .mask      (lane_mask[g]),
         .init_log  (lane_log[g]),
         .desc_addr (lane_addr[g])
      );
   end

   pdr_shared_regs #(.CNT_W(CNT_W), .LOG_W(LOG_W)) u_shared (
      .clk       (clk),
      .rst_n     (rst_n),
      .host_we   (host_we),
      .host_sel  (host_sel),
      .host_wdata(host_wdata),
      .host_rsel (host_rsel),
      .host_rdata(host_rdata),
      .init_data (op == OP_INIT_DATA),
      .req_log   (lane_log[0]),
      .cmp_log   (lane_log[1]),
      .init_msg  (op == OP_INIT_MSG),
      .msg_log   (lane_log[2]),
      .flush_req (op == OP_FLUSH_REQ),
      .req_cnt   (lane_cnt[0]),
      .flush_cmp (op == OP_FLUSH_CMP),
      .cmp_cnt   (lane_cnt[1]),
      .flush_msg (op == OP_FLUSH_MSG),
      .msg_cnt   (lane_cnt[2]),
      .req_prod  (sh_req_prod),
      .msg_prod  (sh_msg_prod),
      .msg_cons  (sh_msg_cons)
   );

   // message room: outstanding entries below ring size, modulo counter width
   logic [CNT_W:0] msg_used, msg_size;
   always_comb begin
      msg_used = {1'b0, sh_msg_prod - sh_msg_cons};
      msg_size = {1'b0, lane_mask[2]} + (CNT_W + 1)'(1);
      msg_room = (msg_used < msg_size);
   end

   // result register: one cycle after the pop
   logic              av_q;
   logic [ADDR_W-1:0] addr_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         av_q   <= 1'b0;
         addr_q <= '0;
      end else begin
         av_q <= (op == OP_POP_REQ) || (op == OP_POP_CMP) || (op == OP_POP_MSG);
         unique case (op)
            OP_POP_REQ: addr_q <= req_empty ? '0 : lane_addr[0];
            OP_POP_CMP: addr_q <= lane_addr[1];
            OP_POP_MSG: addr_q <= lane_addr[2];
            default:    addr_q <= '0;
         endcase
      end
   end
   assign addr_valid = av_q;
   assign desc_addr  = addr_q;

   // R4
   null_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_POP_REQ && req_empty) |=> (addr_valid && desc_addr == '0));
   // R4
   empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_POP_REQ && req_empty) |=> $stable(lane_cnt[0]));

endmodule

// File: tb/pdr_index_mgr_tb.sv
`timescale 1ns/1ps
module pdr_index_mgr_tb;

   typedef struct packed {
      logic [3:0]  op;
      logic [1:0]  ring;
      logic [4:0]  idx;
      logic [19:0] data;
      logic        hw;
      logic [3:0]  hsel;
      logic [31:0] hdata;
      logic        chk;
      logic [31:0] exp;
      logic [3:0]  rq;
   } vec_t;

   // setup, pops (R3 R4 R5), flush (R7)
   localparam vec_t VECS [14] = '{
      '{4'd1, 2'd0, 5'd0, 20'h00100, 1'b0, 4'd0, 32'd0, 1'b0, 32'h0,        4'd3},
      '{4'd1, 2'd0, 5'd1, 20'h002A5, 1'b0, 4'd0, 32'd0, 1'b0, 32'h0,        4'd3},
      '{4'd1, 2'd1, 5'd0, 20'h00333, 1'b0, 4'd0, 32'd0, 1'b0, 32'h0,        4'd5},
      '{4'd1, 2'd2, 5'd0, 20'h000AB, 1'b0, 4'd0, 32'd0, 1'b0, 32'h0,        4'd3},
      '{4'd2, 2'd0, 5'd0, 20'h00102, 1'b0, 4'd0, 32'd0, 1'b0, 32'h0,        4'd2},
      '{4'd3, 2'd0, 5'd0, 20'h00001, 1'b0, 4'd0, 32'd0, 1'b0, 32'h0,        4'd9},
      '{4'd0, 2'd0, 5'd0, 20'h00000, 1'b1, 4'd0, 32'd2, 1'b0, 32'h0,        4'd4},
      '{4'd4, 2'd0, 5'd0, 20'h00000, 1'b0, 4'd0, 32'd0, 1'b1, 32'h00100000, 4'd3},
      '{4'd4, 2'd0, 5'd0, 20'h00000, 1'b0, 4'd0, 32'd0, 1'b1, 32'h00100080, 4'd3},
      '{4'd4, 2'd0, 5'd0, 20'h00000, 1'b0, 4'd0, 32'd0, 1'b1, 32'h00000000, 4'd4},
      '{4'd5, 2'd0, 5'd0, 20'h00000, 1'b0, 4'd0, 32'd0, 1'b1, 32'h00333000, 4'd5},
      '{4'd5, 2'd0, 5'd0, 20'h00000, 1'b0, 4'd0, 32'd0, 1'b1, 32'h00333020, 4'd5},
      '{4'd6, 2'd0, 5'd0, 20'h00000, 1'b0, 4'd0, 32'd0, 1'b1, 32'h000AB000, 4'd3},
      '{4'd7, 2'd0, 5'd0, 20'h00000, 1'b0, 4'd0, 32'd0, 1'b0, 32'h0,        4'd7}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  op_code = '0;
   logic [1:0]  op_ring = '0;
   logic [4:0]  op_idx = '0;
   logic [19:0] op_data = '0;
   logic        host_we = 1'b0;
   logic [3:0]  host_sel = '0;
   logic [31:0] host_wdata = '0;
   logic [3:0]  host_rsel = '0;
   logic [31:0] host_rdata;
   logic        addr_valid;
   logic [31:0] desc_addr;
   logic        req_empty;
   logic        msg_room;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   pdr_index_mgr u_dut (
      .clk(clk), .rst_n(rst_n), .op_code(op_code), .op_ring(op_ring),
      .op_idx(op_idx), .op_data(op_data), .host_we(host_we),
      .host_sel(host_sel), .host_wdata(host_wdata), .host_rsel(host_rsel),
      .host_rdata(host_rdata), .addr_valid(addr_valid), .desc_addr(desc_addr),
      .req_empty(req_empty), .msg_room(msg_room)
   );

   task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic apply(input logic [3:0] o, input logic [1:0] r, input logic [4:0] i,
                        input logic [19:0] d, input logic hw, input logic [3:0] hs,
                        input logic [31:0] hd);
      op_code = o; op_ring = r; op_idx = i; op_data = d;
      host_we = hw; host_sel = hs; host_wdata = hd;
      @(posedge clk);
      @(negedge clk);
      op_code = '0; host_we = 1'b0;
   endtask

   task automatic op(input logic [3:0] o, input logic [19:0] d);
      apply(o, 2'd0, 5'd0, d, 1'b0, 4'd0, 32'd0);
   endtask

   task automatic hwr(input logic [3:0] s, input logic [31:0] v);
      apply(4'd0, 2'd0, 5'd0, 20'd0, 1'b1, s, v);
   endtask

   task automatic rd(input logic [3:0] s, output logic [31:0] v);
      host_rsel = s;
      #0.5;
      v = host_rdata;
   endtask

   task automatic chk_field(input string rq, input logic [3:0] s, input logic [31:0] exp);
      logic [31:0] v;
      rd(s, v);
      check(rq, v, exp);
   endtask

   // request ring model: 2 pages of 32 entries, 128-byte descriptors
   function automatic logic [31:0] exp_req(input int c);
      int m;
      m = c & 63;
      return (((m >> 5) == 0) ? 32'h00100000 : 32'h002A5000) + 32'((m & 31) * 128);
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #0.5;
      // R1 reset state
      check("R1 addr_valid", {31'b0, addr_valid}, 32'd0);
      check("R1 req_empty", {31'b0, req_empty}, 32'd1);
      check("R1 msg_room", {31'b0, msg_room}, 32'd1);
      for (int f = 0; f < 9; f++) chk_field("R1 field", 4'(f), 32'd0);

      for (int k = 0; k < 14; k++) begin
         apply(VECS[k].op, VECS[k].ring, VECS[k].idx, VECS[k].data,
               VECS[k].hw, VECS[k].hsel, VECS[k].hdata);
         check($sformatf("R%0d valid v%0d", VECS[k].rq, k), {31'b0, addr_valid}, {31'b0, VECS[k].chk});
         if (VECS[k].chk)
            check($sformatf("R%0d addr v%0d", VECS[k].rq, k), desc_addr, VECS[k].exp);
      end

      chk_field("R7 req cons", 4'd1, 32'd2);
      chk_field("R2 req log2", 4'd2, 32'd6);
      chk_field("R2 cmp log2", 4'd5, 32'd7);
      chk_field("R2 msg log2", 4'd8, 32'd5);
      check("R4 empty", {31'b0, req_empty}, 32'd1);

      op(4'd8, 20'd0);
      chk_field("R7 cmp prod", 4'd3, 32'd2);
      op(4'd9, 20'd0);
      chk_field("R7 msg prod", 4'd6, 32'd1);

      // R6 / R12: pops across page boundary and wrap
      hwr(4'd0, 32'd70);
      check("R4 not empty", {31'b0, req_empty}, 32'd0);
      for (int c = 2; c < 64; c++) begin
         op(4'd4, 20'd0);
         check("R3 walk", desc_addr, exp_req(c));
      end
      op(4'd4, 20'd0);
      check("R6 wrap", desc_addr, 32'h00100000);
      op(4'd7, 20'd0);
      chk_field("R12 unmasked", 4'd1, 32'd65);

      // R8 message room window (mask 31)
      hwr(4'd7, 32'd0);
      check("R8 room 1", {31'b0, msg_room}, 32'd1);
      hwr(4'd6, 32'd32);
      check("R8 full", {31'b0, msg_room}, 32'd0);
      hwr(4'd7, 32'd1);
      check("R8 room 31", {31'b0, msg_room}, 32'd1);
      hwr(4'd6, 32'd3);
      hwr(4'd7, 32'hFFFFFFF0);
      check("R8 wrap room", {31'b0, msg_room}, 32'd1);
      hwr(4'd7, 32'hFFFFFFE0);
      check("R8 wrap full", {31'b0, msg_room}, 32'd0);

      // R9 message init only
      op(4'd3, 20'd2);
      chk_field("R9 msg log2", 4'd8, 32'd6);
      chk_field("R9 msg prod", 4'd6, 32'd0);
      chk_field("R9 msg cons", 4'd7, 32'd0);
      chk_field("R9 req cons kept", 4'd1, 32'd65);
      chk_field("R9 cmp prod kept", 4'd3, 32'd2);

      // R11 priority
      apply(4'd7, 2'd0, 5'd0, 20'd0, 1'b1, 4'd1, 32'h55);
      chk_field("R11 block wins", 4'd1, 32'd65);
      apply(4'd8, 2'd0, 5'd0, 20'd0, 1'b1, 4'd0, 32'd0);
      chk_field("R11 host applied", 4'd0, 32'd0);

      // R10 clear
      op(4'd10, 20'd0);
      check("R10 req counter", {31'b0, req_empty}, 32'd1);
      op(4'd5, 20'd0);
      check("R10 cmp valid", {31'b0, addr_valid}, 32'd1);
      check("R10 cmp addr", desc_addr, 32'd0);
      op(4'd6, 20'd0);
      check("R10 msg addr", desc_addr, 32'd0);
      chk_field("R10 shared kept", 4'd3, 32'd2);

      // R2 non power-of-two page count
      op(4'd2, 20'h00301);
      chk_field("R2 cmp log2 3pg", 4'd5, 32'd9);
      chk_field("R2 req log2 1pg", 4'd2, 32'd5);
      chk_field("R2 cmp prod zero", 4'd3, 32'd0);
      chk_field("R2 req cons zero", 4'd1, 32'd0);

      // R5 completion pops never gated
      apply(4'd1, 2'd1, 5'd2, 20'h00444, 1'b0, 4'd0, 32'd0);
      for (int c = 0; c < 256; c++) op(4'd5, 20'd0);
      op(4'd5, 20'd0);
      check("R5 page2", desc_addr, 32'h00444000);
      op(4'd8, 20'd0);
      chk_field("R5 cmp count", 4'd3, 32'd257);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule